// File: doc/BRIEF.md
# Composite Sync and Blank Combiner with Equalization and Serration Insertion

This block merges the separate horizontal and vertical timing pulses of a video raster generator into one composite sync line and one composite blank line. Blanking is simply the union of the horizontal and vertical blanking intervals. Sync is normally the union of horizontal and vertical sync. Inside a programmable band of vertical counts it can instead produce equalization pulses and serration pulses. Serration pulses stand in for the vertical sync interval, and equalization pulses fill the rest of the band.

The block receives the running horizontal and vertical counts, the four raw active-high pulses, a two-bit rate mode, an insertion enable and six timing values. The horizontal count runs from 1 up to the programmed line length. In double-rate modes the pulses repeat every half line. The half-line position is found by folding the horizontal count around half the line length, so the line length must be even. Single-rate mode produces one pulse per line. Interlaced operation always uses double rate. The one reserved mode code is handled as single rate and latches an error flag. All outputs are active high. Polarity selection belongs to the stage downstream.

Top module: `csync_combine`

## Requirements
- R1: `comp_blank` equals `h_blank | v_blank` sampled at the previous rising clock edge.
- R2: When `ins_en` is 0, or `v_cnt` lies outside the insertion band, `comp_sync` equals `h_sync | v_sync` sampled at the previous rising edge.
- R3: The insertion band is `win_lo <= v_cnt < win_hi`. The lower bound is inside the band and the upper bound is outside it.
- R4: Inside the band with `ins_en` = 1 and `v_sync` = 0, `comp_sync` is 1 exactly when the position p satisfies `h_front <= p < eq_end`, whatever the value of `h_sync` (equalization pulse).
- R5: Inside the band with `ins_en` = 1 and `v_sync` = 1, `comp_sync` is 1 exactly when `h_front <= p < ser_end` (serration pulse).
- R6: In double rate, p = `h_cnt - hmax/2` when `h_cnt > hmax/2`, and p = `h_cnt` otherwise. This gives two pulses per line.
- R7: In single rate, p = `h_cnt`, giving one pulse per line.
- R8: `mode_sel` codes: 2'b00 selects interlaced double rate, 2'b01 non-interlaced double rate and 2'b11 non-interlaced single rate. 2'b10 is reserved, acts as 2'b11 and sets `mode_err` one cycle later.
- R9: Reset (`rst` = 1, synchronous) drives `comp_sync`, `comp_blank` and `mode_err` to 0. Once set, `mode_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Rate mode code |
| ins_en | input | 1 | Enables equalization/serration insertion |
| hmax | input | CNT_W | Clocks per line, even |
| h_front | input | CNT_W | Pulse start position |
| eq_end | input | CNT_W | Equalization pulse end position |
| ser_end | input | CNT_W | Serration pulse end position |
| win_lo | input | CNT_W | First vertical count of insertion band |
| win_hi | input | CNT_W | Vertical count just past the band |
| h_cnt | input | CNT_W | Horizontal count, 1..hmax |
| v_cnt | input | CNT_W | Vertical count |
| h_sync | input | 1 | Raw horizontal sync, active high |
| v_sync | input | 1 | Raw vertical sync, active high |
| h_blank | input | 1 | Raw horizontal blank, active high |
| v_blank | input | 1 | Raw vertical blank, active high |
| comp_sync | output | 1 | Composite sync, active high |
| comp_blank | output | 1 | Composite blank, active high |
| mode_err | output | 1 | Sticky reserved-mode flag |

## Verification
The bench builds the block with the default `CNT_W` = 12 and the registered output variant. It programs a 20-clock line, so the half-line fold happens at count 10. With timing values 2, 4 and 8 and a band from 5 to 9, every pulse edge, both band bounds and the fold point sit within a few counts of each other. This lets single vectors hit each side of every comparison. The same positions are replayed under every mode code, so the results show the difference between one and two pulses per line and the handling of the reserved code.

// File: rtl/csync_pkg.sv
package csync_pkg;

   typedef enum logic [1:0] {
      RATE_ILACE_DBL = 2'b00,
      RATE_PROG_DBL  = 2'b01,
      RATE_RESERVED  = 2'b10,
      RATE_PROG_SGL  = 2'b11
   } rate_mode_e;

   typedef struct packed {
      logic dbl;
      logic ilace;
      logic bad;
   } rate_dec_t;

   function automatic rate_dec_t decode_rate(input logic [1:0] code);
      rate_dec_t d;
      d = '0;
      case (rate_mode_e'(code))
         RATE_ILACE_DBL: begin d.dbl = 1'b1; d.ilace = 1'b1; end
         RATE_PROG_DBL:  begin d.dbl = 1'b1; end
         RATE_RESERVED:  begin d.bad = 1'b1; end
         default:        begin d.dbl = 1'b0; end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/csync_mode_dec.sv
module csync_mode_dec
   import csync_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode_sel,
   output rate_dec_t  dec,
   output logic       err
);

   logic err_q;

   always_comb dec = decode_rate(mode_sel);

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= err_q | dec.bad;
   end

   assign err = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_q |=> err_q); // R9

   AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b10) |=> err_q); // R8

endmodule

// File: rtl/csync_phase.sv
module csync_phase #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dbl,
   input  logic [CNT_W-1:0] hmax,
   input  logic [CNT_W-1:0] h_cnt,
   output logic [CNT_W-1:0] pos
);

   logic [CNT_W-1:0] half;

   always_comb begin
      half = hmax >> 1;
      if (dbl && (h_cnt > half)) pos = h_cnt - half;
      else                       pos = h_cnt;
   end

   AST_HMAX_EVEN: assert property (@(posedge clk) disable iff (rst)
      dbl |-> !hmax[0]); // R6

   AST_POS_FOLDED: assert property (@(posedge clk) disable iff (rst)
      (dbl && h_cnt >= 1 && h_cnt <= hmax) |-> (pos >= 1 && pos <= (hmax >> 1))); // R6

endmodule

// File: rtl/csync_pulse_gen.sv
module csync_pulse_gen #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ins_en,
   input  logic             v_sync,
   input  logic [CNT_W-1:0] pos,
   input  logic [CNT_W-1:0] v_cnt,
   input  logic [CNT_W-1:0] h_front,
   input  logic [CNT_W-1:0] eq_end,
   input  logic [CNT_W-1:0] ser_end,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   output logic             ins_act,
   output logic             pulse
);

   logic in_band;
   logic eq_on;
   logic ser_on;

   always_comb begin
      in_band = (v_cnt >= win_lo) && (v_cnt < win_hi);
      ins_act = ins_en && in_band;
      eq_on   = (pos >= h_front) && (pos < eq_end);
      ser_on  = (pos >= h_front) && (pos < ser_end);
      pulse   = v_sync ? ser_on : eq_on;
   end

   AST_EQ_ENDS: assert property (@(posedge clk) disable iff (rst)
      (ins_act && !v_sync && pos >= eq_end) |-> !pulse); // R4

   AST_SER_ENDS: assert property (@(posedge clk) disable iff (rst)
      (ins_act && v_sync && pos >= ser_end) |-> !pulse); // R5

   AST_BEFORE_FRONT: assert property (@(posedge clk) disable iff (rst)
      (pos < h_front) |-> !pulse); // R4

endmodule

// File: rtl/csync_combine.sv
module csync_combine
   import csync_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode_sel,
   input  logic             ins_en,
   input  logic [CNT_W-1:0] hmax,
   input  logic [CNT_W-1:0] h_front,
   input  logic [CNT_W-1:0] eq_end,
   input  logic [CNT_W-1:0] ser_end,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   input  logic [CNT_W-1:0] h_cnt,
   input  logic [CNT_W-1:0] v_cnt,
   input  logic             h_sync,
   input  logic             v_sync,
   input  logic             h_blank,
   input  logic             v_blank,
   output logic             comp_sync,
   output logic             comp_blank,
   output logic             mode_err
);

   localparam int HALF_W = CNT_W - 1;

   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_width
      $error("csync_combine: CNT_W must lie in 4..16");
   end
   if (HALF_W < 3) begin : g_bad_half
      $error("csync_combine: half-line width too small");
   end

   rate_dec_t        dec;
   logic [CNT_W-1:0] pos;
   logic             ins_act;
   logic             pulse;
   logic             sync_nx;
   logic             blank_nx;

   csync_mode_dec u_mode (
      .clk      (clk),
      .rst      (rst),
      .mode_sel (mode_sel),
      .dec      (dec),
      .err      (mode_err)
   );

   csync_phase #(.CNT_W(CNT_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .dbl   (dec.dbl),
      .hmax  (hmax),
      .h_cnt (h_cnt),
      .pos   (pos)
   );

   csync_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
      .clk     (clk),
      .rst     (rst),
      .ins_en  (ins_en),
      .v_sync  (v_sync),
      .pos     (pos),
      .v_cnt   (v_cnt),
      .h_front (h_front),
      .eq_end  (eq_end),
      .ser_end (ser_end),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .ins_act (ins_act),
      .pulse   (pulse)
   );

   always_comb begin
      blank_nx = h_blank | v_blank;
      sync_nx  = ins_act ? pulse : (h_sync | v_sync);
   end

   if (OUT_REG) begin : g_reg_out
      logic sync_q;
      logic blank_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            sync_q  <= 1'b0;
            blank_q <= 1'b0;
         end else begin
            sync_q  <= sync_nx;
            blank_q <= blank_nx;
         end
      end

      assign comp_sync  = sync_q;
      assign comp_blank = blank_q;

      AST_BLANK_UNION: assert property (@(posedge clk) disable iff (rst)
         (h_blank || v_blank) |=> comp_blank); // R1

      AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (rst)
         (!h_blank && !v_blank) |=> !comp_blank); // R1

      AST_PLAIN_SYNC: assert property (@(posedge clk) disable iff (rst)
         !ins_act |=> (comp_sync == $past(h_sync | v_sync))); // R2

      AST_NO_INSERT_OFF: assert property (@(posedge clk) disable iff (rst)
         !ins_en |-> !ins_act); // R2
   end else begin : g_comb_out
      assign comp_sync  = rst ? 1'b0 : sync_nx;
      assign comp_blank = rst ? 1'b0 : blank_nx;
   end

endmodule

// File: tb/csync_combine_test.sv
module csync_combine_test;

   localparam int W = 12;
   localparam int NV = 20;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   mode_sel = 2'b01;
   logic         ins_en = 1'b0;
   logic [W-1:0] hmax = 12'd20, h_front = 12'd2, eq_end = 12'd4, ser_end = 12'd8;
   logic [W-1:0] win_lo = 12'd5, win_hi = 12'd9;
   logic [W-1:0] h_cnt = 12'd1, v_cnt = 12'd1;
   logic         h_sync = 1'b0, v_sync = 1'b0, h_blank = 1'b0, v_blank = 1'b0;
   logic         comp_sync, comp_blank, mode_err;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   csync_combine uut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .ins_en(ins_en),
      .hmax(hmax), .h_front(h_front), .eq_end(eq_end), .ser_end(ser_end),
      .win_lo(win_lo), .win_hi(win_hi), .h_cnt(h_cnt), .v_cnt(v_cnt),
      .h_sync(h_sync), .v_sync(v_sync), .h_blank(h_blank), .v_blank(v_blank),
      .comp_sync(comp_sync), .comp_blank(comp_blank), .mode_err(mode_err)
   );

   // {mode[1:0], en, hcnt[7:0], vcnt[7:0], hs, vs, hb, vb, exp_sync, exp_blank, tag[3:0]}
   // Bench timing: hmax 20 (half 10), front 2, eq end 4, ser end 8, band [5,9)
   localparam logic [28:0] VECS [NV] = '{
      {2'b01,1'b0,8'd3, 8'd6,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd1}, // R1 blank via h
      {2'b01,1'b0,8'd3, 8'd6,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,4'd2}, // R2 disabled
      {2'b01,1'b0,8'd3, 8'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 disabled idle
      {2'b01,1'b1,8'd3, 8'd4,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'd3}, // R3 below band
      {2'b01,1'b1,8'd3, 8'd9,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 upper bound out
      {2'b01,1'b1,8'd3, 8'd5,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd3}, // R3 lower bound in
      {2'b01,1'b1,8'd4, 8'd5,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // R4 eq ends, hs ignored
      {2'b01,1'b1,8'd1, 8'd6,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd4}, // R4 before front
      {2'b01,1'b1,8'd2, 8'd8,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd4}, // R4 at front
      {2'b01,1'b1,8'd7, 8'd6,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5}, // R5 serration last
      {2'b01,1'b1,8'd8, 8'd6,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd5}, // R5 serration end
      {2'b01,1'b1,8'd12,8'd8,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd6}, // R6 second eq pulse
      {2'b01,1'b1,8'd14,8'd8,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 second eq end
      {2'b01,1'b1,8'd11,8'd8,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 fold to 1
      {2'b01,1'b1,8'd17,8'd6,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,4'd6}, // R6 second serration
      {2'b11,1'b1,8'd12,8'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 no fold
      {2'b11,1'b1,8'd3, 8'd5,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd7}, // R7 one pulse
      {2'b00,1'b1,8'd12,8'd5,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,4'd8}, // R8 interlaced double
      {2'b10,1'b1,8'd12,8'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd8}, // R8 reserved as single
      {2'b10,1'b1,8'd3, 8'd5,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd8}  // R8 reserved as single
   };

   task automatic check(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", what, act, exp);
      end
   endtask

   initial begin : watchdog
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset comp_sync", comp_sync, 1'b0);
      check("R9 reset comp_blank", comp_blank, 1'b0);
      check("R9 reset mode_err", mode_err, 1'b0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         mode_sel = VECS[i][28:27];
         ins_en   = VECS[i][26];
         h_cnt    = W'(VECS[i][25:18]);
         v_cnt    = W'(VECS[i][17:10]);
         h_sync   = VECS[i][9];
         v_sync   = VECS[i][8];
         h_blank  = VECS[i][7];
         v_blank  = VECS[i][6];
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec %0d comp_sync", VECS[i][3:0], i), comp_sync, VECS[i][5]);
         check($sformatf("R%0d vec %0d comp_blank", VECS[i][3:0], i), comp_blank, VECS[i][4]);
      end
      check("R8 reserved code sets mode_err", mode_err, 1'b1);

      // R9: flag holds after a legal mode returns
      @(negedge clk);
      mode_sel = 2'b01;
      repeat (4) @(posedge clk);
      #1;
      check("R9 mode_err sticky", mode_err, 1'b1);

      // R1: vertical blank alone
      @(negedge clk);
      h_blank = 1'b0; v_blank = 1'b1;
      @(posedge clk);
      #1;
      check("R1 v_blank only", comp_blank, 1'b1);

      // R9: reset clears the flag
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R9 reset clears mode_err", mode_err, 1'b0);
      check("R9 reset clears comp_blank", comp_blank, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check("R9 mode_err stays clear in legal mode", mode_err, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule